// File: doc/BRIEF.md
# Match-Preload Timer with Snapshot Read

A bank of independent up-counters reached through a simple synchronous register port. Every counter owns a set of match comparators, a preload value and a reload control. The reload control picks one comparator. When the counter reaches that comparator's value while running, it jumps back to the preload value instead of counting on. With the chosen match at all ones and a preload of zero, the counter behaves as a plain free-running counter that wraps at its full width. A shared count-enable register starts and stops each counter. A stopped counter keeps its value, and when it is enabled again it counts on from that value.

Software never reads a counter directly. A write to a timer's snapshot register samples the counter on that clock edge. The sampled value becomes readable in the same register a fixed number of cycles later. Until then, a busy flag shows in the timer's status register. Each comparator also sets a sticky status bit when the running counter equals it. Status bits can be masked onto a per-timer interrupt line, and they are cleared by writing ones.

Top module: `match_timer`

## Requirements
- R1: After reset all counters, match, preload, control, enable, interrupt-enable, status and snapshot registers read 0 and `irq_o` is 0.
- R2: While bit t of the count-enable register (address 0x24) is 1, counter t advances once per clock. While the bit is 0 the counter holds its value, and re-enabling resumes from the held value.
- R3: The match register for comparator c of timer t sits at word address 3*t+c. The preload sits at 0x10+t and the reload control at 0x14+t, with bit 0 = reload enable and bits [2:1] = comparator index. While running with reload enabled, a count equal to the selected match makes the next count the preload value, so writing 1 selects comparator 0.
- R4: With match 0xFFFFFFFF and preload 0 the counter rolls from 0xFFFFFFFF to 0. With reload disabled it also rolls from 0xFFFFFFFF to 0.
- R5: Status register 0x18+t bit c is set on a clock edge where timer t runs and its count equals match c. The bit stays set otherwise and is never set while the timer is stopped.
- R6: The interrupt-enable register at 0x1C+t (bits [2:0]) masks the status bits. `irq_o[t]` is 1 exactly while some status bit of timer t and its enable bit are both 1.
- R7: Writing ones to 0x20+t clears the matching status bits. Zero bits leave status unchanged, and a match in the same cycle wins over the clear.
- R8: A write to 0x28+t with data bit 0 = 1 samples counter t on that edge. Reads of 0x28+t return the previous snapshot until exactly CAP_LAT cycles later, then the new one. A write with bit 0 = 0 changes nothing.
- R9: Status bit 3 (bit NUM_CMP) of timer t is 1 from the request edge until the snapshot lands, at most 4 cycles.
- R10: Match, preload, control, interrupt-enable and count-enable registers read back what was written. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| waddr_i | input | 6 | Write word address |
| wdata_i | input | DW | Write data |
| raddr_i | input | 6 | Read word address |
| rdata_o | output | DW | Read data, combinational from raddr_i |
| irq_o | output | NUM_TMR | Per-timer interrupt |

## Verification
The bench builds the block with the defaults: three timers, three comparators, 32-bit counters and a snapshot latency of 3. The full 32-bit width together with preload lets a counter be parked just below 0xFFFFFFFF in a few cycles, so both roll-over paths are reached quickly. A latency of 3 leaves two reads between request and landing, where the busy flag and the stale snapshot can be observed before the new value appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_MATCH = 6'h00;
  localparam logic [AW-1:0] A_PRE   = 6'h10;
  localparam logic [AW-1:0] A_PCTL  = 6'h14;
  localparam logic [AW-1:0] A_STS   = 6'h18;
  localparam logic [AW-1:0] A_IE    = 6'h1C;
  localparam logic [AW-1:0] A_ICLR  = 6'h20;
  localparam logic [AW-1:0] A_CEN   = 6'h24;
  localparam logic [AW-1:0] A_SNAP  = 6'h28;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DW = 32,
  parameter int NC = 3,
  parameter int SW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [NC-1:0][DW-1:0]  match_i,
  input  logic [DW-1:0]          preload_i,
  input  logic                   rld_en_i,
  input  logic [SW-1:0]          rld_sel_i,
  input  logic [NC-1:0]          ie_i,
  input  logic [NC-1:0]          clr_i,
  output logic [DW-1:0]          count_o,
  output logic [NC-1:0]          sts_o,
  output logic                   irq_o
);
  logic [NC-1:0] hit;
  logic          sel_hit;

  for (genvar c = 0; c < NC; c++) begin : g_cmp
    assign hit[c] = run_i && (count_o == match_i[c]);
  end

  always_comb begin
    sel_hit = 1'b0;
    for (int c = 0; c < NC; c++)
      if (rld_sel_i == SW'(c)) sel_hit = hit[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      sts_o   <= '0;
    end else begin
      if (run_i) count_o <= (rld_en_i && sel_hit) ? preload_i : count_o + 1'b1;
      sts_o <= (sts_o & ~clr_i) | hit;
    end
  end

  assign irq_o = |(sts_o & ie_i);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> count_o == $past(count_o));
  a_r2_incr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !rld_en_i) |=> count_o == $past(count_o) + 1'b1);
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rld_en_i && rld_sel_i == '0 && count_o == match_i[0])
    |=> count_o == $past(preload_i));

  for (genvar c = 0; c < NC; c++) begin : g_chk
    a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && count_o == match_i[c]) |=> sts_o[c]);
    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !(run_i && count_o == match_i[c])) |=> !sts_o[c]);
  end
endmodule

// File: rtl/tmr_snapshot.sv
module tmr_snapshot #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] count_i,
  output logic [DW-1:0] snap_o,
  output logic          busy_o
);
  localparam int PW = $clog2(LAT + 1);

  logic [PW-1:0] pend_q;
  logic [DW-1:0] shadow_q;

  // sample on request edge, publish after a fixed delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      shadow_q <= '0;
      snap_o   <= '0;
    end else if (req_i) begin
      pend_q   <= PW'(LAT);
      shadow_q <= count_i;
    end else if (pend_q != '0) begin
      pend_q <= pend_q - 1'b1;
      if (pend_q == PW'(1)) snap_o <= shadow_q;
    end
  end

  assign busy_o = (pend_q != '0);

  a_r9_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> busy_o);
  a_r8_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q == PW'(1) && !req_i) |=> $stable(snap_o));
  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> !busy_o);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int NUM_CMP = 3,
  parameter int DW      = 32,
  parameter int CAP_LAT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [5:0]         waddr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [5:0]         raddr_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NUM_TMR-1:0] irq_o
);
  localparam int NMATCH = NUM_TMR * NUM_CMP;
  localparam int SW     = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
  localparam int CTLW   = SW + 1;

  logic [DW-1:0]      match_q [NMATCH];
  logic [DW-1:0]      pre_q   [NUM_TMR];
  logic [CTLW-1:0]    pctl_q  [NUM_TMR];
  logic [NUM_CMP-1:0] ie_q    [NUM_TMR];
  logic [NUM_TMR-1:0] cen_q;

  logic [NUM_TMR-1:0][NUM_CMP-1:0][DW-1:0] tmatch;
  logic [NUM_CMP-1:0] clr_w  [NUM_TMR];
  logic [NUM_CMP-1:0] sts_w  [NUM_TMR];
  logic [DW-1:0]      cnt_w  [NUM_TMR];
  logic [DW-1:0]      snap_w [NUM_TMR];
  logic [NUM_TMR-1:0] cap_w;
  logic [NUM_TMR-1:0] busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NMATCH; i++) match_q[i] <= '0;
      for (int t = 0; t < NUM_TMR; t++) begin
        pre_q[t]  <= '0;
        pctl_q[t] <= '0;
        ie_q[t]   <= '0;
      end
      cen_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NMATCH; i++)
        if (waddr_i == A_MATCH + 6'(i)) match_q[i] <= wdata_i;
      for (int t = 0; t < NUM_TMR; t++) begin
        if (waddr_i == A_PRE  + 6'(t)) pre_q[t]  <= wdata_i;
        if (waddr_i == A_PCTL + 6'(t)) pctl_q[t] <= wdata_i[CTLW-1:0];
        if (waddr_i == A_IE   + 6'(t)) ie_q[t]   <= wdata_i[NUM_CMP-1:0];
      end
      if (waddr_i == A_CEN) cen_q <= wdata_i[NUM_TMR-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_m
      assign tmatch[t][c] = match_q[t*NUM_CMP + c];
    end
    assign clr_w[t] = (wr_en_i && waddr_i == A_ICLR + 6'(t)) ? wdata_i[NUM_CMP-1:0] : '0;
    assign cap_w[t] = wr_en_i && (waddr_i == A_SNAP + 6'(t)) && wdata_i[0];

    tmr_counter #(.DW(DW), .NC(NUM_CMP), .SW(SW)) i_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (cen_q[t]),
      .match_i   (tmatch[t]),
      .preload_i (pre_q[t]),
      .rld_en_i  (pctl_q[t][0]),
      .rld_sel_i (pctl_q[t][CTLW-1:1]),
      .ie_i      (ie_q[t]),
      .clr_i     (clr_w[t]),
      .count_o   (cnt_w[t]),
      .sts_o     (sts_w[t]),
      .irq_o     (irq_o[t])
    );

    tmr_snapshot #(.DW(DW), .LAT(CAP_LAT)) i_snap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (cap_w[t]),
      .count_i (cnt_w[t]),
      .snap_o  (snap_w[t]),
      .busy_o  (busy_w[t])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NMATCH; i++)
      if (raddr_i == A_MATCH + 6'(i)) rdata_o = match_q[i];
    for (int t = 0; t < NUM_TMR; t++) begin
      if (raddr_i == A_PRE  + 6'(t)) rdata_o = pre_q[t];
      if (raddr_i == A_PCTL + 6'(t)) rdata_o = DW'(pctl_q[t]);
      if (raddr_i == A_STS  + 6'(t)) rdata_o = DW'({busy_w[t], sts_w[t]});
      if (raddr_i == A_IE   + 6'(t)) rdata_o = DW'(ie_q[t]);
      if (raddr_i == A_SNAP + 6'(t)) rdata_o = snap_w[t];
    end
    if (raddr_i == A_CEN) rdata_o = DW'(cen_q);
  end

  a_r1_irq_reset: assert property (@(posedge clk_i) $rose(rst_ni) |-> irq_o == '0);
  a_r2_stop_cen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && waddr_i == A_CEN) |=> cen_q == $past(wdata_i[NUM_TMR-1:0]));
endmodule

// File: tb/test_match_timer.sv
module test_match_timer;
  import tmr_pkg::*;
  localparam int NT = 3, NC = 3, DW = 32, LAT = 3;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [NT-1:0] irq;

  always #10 clk = ~clk;

  match_timer #(.NUM_TMR(NT), .NUM_CMP(NC), .DW(DW), .CAP_LAT(LAT)) i_match_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata), .irq_o(irq));

  typedef struct { logic [5:0] addr; logic [31:0] exp; bit is_irq; int req; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_act = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0 && !mon_act) begin
      item_t it;
      logic [31:0] got;
      mon_act = 1;
      it = q.pop_front();
      raddr = it.addr;
      #2;
      got = it.is_irq ? 32'(irq) : rdata;
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL R%0d addr=%h irq=%0b got=%h exp=%h", it.req, it.addr, it.is_irq, got, it.exp);
      end
      mon_act = 0;
    end
  end

  // bench model
  logic [31:0] mv[NT], mm[NT*NC], mp[NT], old[NT];
  int mctl[NT], mie[NT], ms[NT];
  int mmask = 0, mlast = 0;

  function automatic void step_all(int n);
    for (int k = 0; k < n; k++)
      for (int t = 0; t < NT; t++)
        if (mmask[t]) begin
          int sel = (mctl[t] >> 1) & 3;
          bit rl = (mctl[t] & 1) && sel < NC && mv[t] == mm[t*NC+sel];
          for (int c = 0; c < NC; c++) if (mv[t] == mm[t*NC+c]) ms[t] |= (1 << c);
          mv[t] = rl ? mp[t] : mv[t] + 1;
        end
  endfunction

  task automatic msync(int x); step_all(x - mlast); mlast = x; endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, output int e);
    @(negedge clk); wr_en = 1; waddr = a; wdata = d;
    @(posedge clk); e = cyc;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk(input logic [5:0] a, input logic [31:0] e, input int r);
    #1; q.push_back('{a, e, 1'b0, r});
  endtask

  task automatic chk_irq(input int r);
    logic [31:0] e = 0;
    for (int t = 0; t < NT; t++) if ((ms[t] & mie[t]) != 0) e[t] = 1'b1;
    #1; q.push_back('{6'h0, e, 1'b1, r});
  endtask

  task automatic wq; wait (q.size() == 0 && !mon_act); endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic cfg(input logic [5:0] a, input logic [31:0] d);
    int e;
    wr(a, d, e);
    if (a < 6'h10) mm[a] = d;
    else if (a >= A_PRE && a < A_PRE + NT) mp[a - A_PRE] = d;
    else if (a >= A_PCTL && a < A_PCTL + NT) mctl[a - A_PCTL] = d & 7;
    else if (a >= A_IE && a < A_IE + NT) mie[a - A_IE] = d & 7;
  endtask

  task automatic set_cen(int m);
    int e;
    wr(A_CEN, m, e); msync(e); mmask = m;
  endtask

  // snapshot of a stopped timer, checks busy and the latency window (R8, R9)
  task automatic snap(int t);
    int e;
    wr(A_SNAP + 6'(t), 1, e);
    chk(A_STS + 6'(t), ms[t] | 8, 9);   // R9 busy after request
    chk(A_SNAP + 6'(t), old[t], 8);     // R8 stale before CAP_LAT
    chk(A_SNAP + 6'(t), mv[t], 8);      // R8 landed
    old[t] = mv[t];
    wq();
  endtask

  initial begin
    int e;
    for (int t = 0; t < NT; t++) begin mv[t] = 0; mp[t] = 0; old[t] = 0; mctl[t] = 0; mie[t] = 0; ms[t] = 0; end
    for (int i = 0; i < NT*NC; i++) mm[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk(A_CEN, 0, 1); chk(A_STS, 0, 1); chk(A_SNAP + 1, 0, 1);
    chk(A_MATCH + 4, 0, 1); chk_irq(1);
    chk(6'h3F, 0, 10);                   // R10 unmapped
    wq();

    // R3 reload on comparator 0 to a high preload
    cfg(A_MATCH + 0, 32'd3); cfg(A_PRE, 32'hFFFF_FFFE); cfg(A_PCTL, 1);
    chk(A_PCTL, 1, 10); chk(A_PRE, 32'hFFFF_FFFE, 10); chk(A_MATCH, 3, 10);
    wq();
    set_cen(1); idle(2); set_cen(0);
    snap(0);                             // R3
    // R4 full-width wrap via all-ones match and zero preload
    cfg(A_MATCH + 0, 32'hFFFF_FFFF); cfg(A_PRE, 0);
    set_cen(1); idle(3); set_cen(0);
    snap(0);                             // R4
    // R4 natural roll-over with reload disabled
    cfg(A_MATCH + 0, 32'd3); cfg(A_PRE, 32'hFFFF_FFFD);
    set_cen(1); set_cen(0);
    cfg(A_PCTL, 0);
    set_cen(1); idle(3); set_cen(0);
    snap(0);                             // R4
    chk(A_STS, ms[0], 5); wq();          // R5
    wr(A_ICLR, 7, e); ms[0] = 0;
    chk(A_STS, 0, 7); wq();              // R7

    // timers 1 and 2: different comparator selects and preloads
    cfg(A_MATCH + 3, 5); cfg(A_MATCH + 4, 3); cfg(A_MATCH + 5, 1000);
    cfg(A_PRE + 1, 2); cfg(A_PCTL + 1, 1); cfg(A_IE + 1, 2);
    cfg(A_MATCH + 6, 7); cfg(A_MATCH + 7, 4); cfg(A_MATCH + 8, 9);
    cfg(A_PRE + 2, 1); cfg(A_PCTL + 2, 3); cfg(A_IE + 2, 1);
    chk(A_IE + 1, 2, 10); chk(A_PCTL + 2, 3, 10); wq();
    set_cen(6); idle(18); set_cen(0);
    chk(A_CEN, 0, 10); wq();
    snap(1); snap(2);                    // R2, R3
    chk(A_STS + 1, ms[1], 5); chk(A_STS + 2, ms[2], 5);
    chk_irq(6); wq();                    // R6
    // R2 hold while stopped, then resume
    idle(5); snap(1);
    set_cen(2); idle(4); set_cen(0);
    snap(1);                             // R2 resume
    // R7 clear one bit, then a zero write
    wr(A_ICLR + 1, 2, e); ms[1] &= ~2;
    chk(A_STS + 1, ms[1], 7); chk_irq(6); wq();
    wr(A_ICLR + 1, 0, e);
    chk(A_STS + 1, ms[1], 7); wq();
    // R8 write with bit 0 clear is ignored
    wr(A_SNAP + 2, 32'hFFFF_FFFE, e);
    idle(LAT);
    chk(A_STS + 2, ms[2], 8); chk(A_SNAP + 2, old[2], 8); wq();
    // R8 capture while running samples on the request edge
    begin
      int p;
      logic [31:0] x;
      set_cen(4); idle(3);
      wr(A_SNAP + 2, 1, p);
      msync(p - 1); x = mv[2];
      idle(2); set_cen(0);
      chk(A_SNAP + 2, x, 8); wq();
      old[2] = x;
    end
    chk(A_STS + 2, ms[2], 9); chk_irq(6); wq();  // R9 busy gone, R6

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule